// File: doc/BRIEF.md
# ECC Read-Modify-Write and Scrub Sequencer

This block sits between a host request port and a single-ported store of 72-bit memory words. Each word holds 64 data bits and 8 check bits. The check bits form a single-error-correct, double-error-detect code: a 7-bit Hamming syndrome plus one overall parity bit. They are generated on every word that is written.

A host write that does not set all byte enables cannot simply be written, because the check bits cover the whole word. The block therefore reads the stored word, merges the new bytes into it, re-encodes the result and writes it back. While that sequence runs, the host is held off through the ready/valid handshake.

On reads, a 2-bit integrity mode decides how the stored word is treated:

- **Ignored** (`00`): the word is not checked.
- **Detect only** (`01`): errors are flagged but the data is not repaired.
- **Correct** (`10`): single-bit errors are corrected.
- **Correct and scrub** (`11`): single-bit errors are corrected and the repaired word is written back to the same address, so a later second upset cannot turn it into an uncorrectable word.

Every detected single-bit or multi-bit error produces a one-cycle event carrying the word address, for use by an error logger.

Top module: `ecc_seq`

## Requirements
- R1: A host write with all 8 byte enables set is accepted without stalling and causes exactly one memory write and no memory read. The write carries the data in bits 63:0 and the check byte in bits 71:64, with all 9 lane enables set (lane L covers bits 8L+7:8L). A later read of that word returns the data with no error flags.
- R2: A host read is accepted in the cycle the memory read is issued. Its response (`rsp_valid` high for one cycle, with data and flags) appears after the second rising clock edge following acceptance. Any error event appears in that same cycle.
- R3: In mode 00 a read returns stored bits 63:0 unchecked, even when they are corrupted. It raises no error flag and no event.
- R4: In mode 01 a word with one flipped bit sets `rsp_sbe` and raises the single-bit event with its address. The data is returned uncorrected and memory is not written.
- R5: In mode 10 a single flipped bit anywhere in the 72 stored bits is corrected in the returned data, flagged as single-bit, and not written back.
- R6: A word with two flipped bits is reported as a multi-bit error in every checking mode (01, 10, 11). The raw data is returned, never a "corrected" value, and no write-back occurs.
- R7: In mode 11 a read that finds a single-bit error writes the corrected, re-encoded word back to the same address, so the stored word equals its error-free encoding again.
- R8: In modes 01 to 11 a write with some byte enables clear performs one memory read, then one full-lane write. The write holds the host bytes where enabled and the stored bytes elsewhere (corrected in modes 10 and 11). `host_ready` is low in the cycle between the two accesses.
- R9: In mode 00 a partial write performs a single memory write and no read. It enables only the selected data byte lanes and leaves the check byte lane disabled.
- R10: A multi-bit error found by the read of a read-modify-write cancels the merge write. It raises the multi-bit event with the word address.
- R11: The single-bit and multi-bit events are never raised in the same cycle, and each lasts one cycle per detected error.
- R12: The host port accepts no new request while a read, a read-modify-write or a scrub write-back is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Integrity mode: 00 off, 01 detect, 10 correct, 11 correct and scrub |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Request accepted when high together with host_valid |
| host_write | input | 1 | 1 write, 0 read |
| host_addr | input | AW | Word address |
| host_wdata | input | 64 | Write data |
| host_be | input | 8 | Byte enables of the write |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 64 | Read response data |
| rsp_sbe | output | 1 | Response had a single-bit error |
| rsp_mbe | output | 1 | Response had a multi-bit error |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (else read, data next cycle) |
| mem_addr | output | AW | Memory word address |
| mem_wmask | output | 9 | Byte-lane write enables, lane 8 is the check byte |
| mem_wdata | output | 72 | Encoded word to memory |
| mem_rdata | input | 72 | Word from memory, one cycle after a read |
| err_sbe_evt | output | 1 | Single-bit error event |
| err_mbe_evt | output | 1 | Multi-bit error event |
| err_addr | output | AW | Word address of the event |

## Verification
Clean words are exercised with a random mix of full writes, partial writes under random byte enables, and reads in the three checking modes. This separates correct merging and encoding from corruption, because any encoder or merge fault shows up as a flag or a data mismatch on readback.

Single flips are injected into data bits and check bits. This separates correction of the data from mere detection, and separates scrub write-back from no write-back by inspecting the stored word afterwards.

Double flips, on both reads and partial writes, distinguish a proper multi-bit report, with the raw data returned and the merge cancelled, from a false correction.

Mode 00 reads and writes of corrupted words show that checking and read-modify-write are fully bypassed.

// File: rtl/ecc_seq_pkg.sv
package ecc_seq_pkg;
    localparam int DATA_W = 64;
    localparam int LANES  = DATA_W / 8;
    localparam int HAM_W  = 7;                    // syndrome width covering positions 1..2**HAM_W-1
    localparam int CODE_W = DATA_W + HAM_W + 1;   // plus overall parity
    localparam int MASK_W = LANES + 1;            // data lanes plus one check lane

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_DETECT  = 2'b01,
        MODE_CORRECT = 2'b10,
        MODE_SCRUB   = 2'b11
    } integ_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_MERGE = 2'b10
    } seq_state_e;

    // Stored layout: [DATA_W-1:0] data, then HAM_W syndrome bits, then overall parity.
    // Hamming layout: position 0 parity, powers of two check bits, the rest data in order.
    function automatic logic [CODE_W-1:0] store_to_pos(input logic [CODE_W-1:0] w);
        logic [CODE_W-1:0] cw;
        int k;
        int j;
        cw    = '0;
        k     = 0;
        j     = 0;
        cw[0] = w[CODE_W-1];
        for (int p = 1; p < CODE_W; p++) begin
            if ((p & (p - 1)) == 0) begin
                cw[p] = w[DATA_W + j];
                j++;
            end else begin
                cw[p] = w[k];
                k++;
            end
        end
        return cw;
    endfunction

    function automatic logic [CODE_W-1:0] pos_to_store(input logic [CODE_W-1:0] cw);
        logic [CODE_W-1:0] w;
        int k;
        int j;
        w           = '0;
        k           = 0;
        j           = 0;
        w[CODE_W-1] = cw[0];
        for (int p = 1; p < CODE_W; p++) begin
            if ((p & (p - 1)) == 0) begin
                w[DATA_W + j] = cw[p];
                j++;
            end else begin
                w[k] = cw[p];
                k++;
            end
        end
        return w;
    endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_seq_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] word
);
    logic [CODE_W-1:0] cw;
    logic [HAM_W-1:0]  syn;

    always_comb begin
        cw  = store_to_pos({{(CODE_W-DATA_W){1'b0}}, data});
        syn = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (cw[p]) syn = syn ^ HAM_W'(p);
        end
        for (int j = 0; j < HAM_W; j++) begin
            cw[1 << j] = syn[j];
        end
        cw[0] = ^cw[CODE_W-1:1];
        word  = pos_to_store(cw);
    end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_seq_pkg::*;
(
    input  logic [CODE_W-1:0] word,
    output logic [DATA_W-1:0] data_raw,
    output logic [DATA_W-1:0] data_fix,
    output logic              sbe,
    output logic              mbe
);
    logic [CODE_W-1:0] cw;
    logic [CODE_W-1:0] fixed_pos;
    logic [CODE_W-1:0] fixed_word;
    logic [HAM_W-1:0]  syn;
    logic              par;

    always_comb begin
        cw  = store_to_pos(word);
        syn = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (cw[p]) syn = syn ^ HAM_W'(p);
        end
        par       = ^cw;
        sbe       = 1'b0;
        mbe       = 1'b0;
        fixed_pos = cw;
        if (par) begin
            // odd weight: one flip, unless the syndrome points outside the word
            if (int'(syn) < CODE_W) begin
                sbe            = 1'b1;
                fixed_pos[syn] = ~cw[syn];
            end else begin
                mbe = 1'b1;
            end
        end else if (syn != '0) begin
            mbe = 1'b1;
        end
        fixed_word = pos_to_store(fixed_pos);
        data_fix   = fixed_word[DATA_W-1:0];
        data_raw   = word[DATA_W-1:0];
    end
endmodule

// File: rtl/ecc_seq.sv
module ecc_seq
    import ecc_seq_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode,
    input  logic                   host_valid,
    output logic                   host_ready,
    input  logic                   host_write,
    input  logic [AW-1:0]          host_addr,
    input  logic [DATA_W-1:0]      host_wdata,
    input  logic [LANES-1:0]       host_be,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_data,
    output logic                   rsp_sbe,
    output logic                   rsp_mbe,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_addr,
    output logic [MASK_W-1:0]      mem_wmask,
    output logic [CODE_W-1:0]      mem_wdata,
    input  logic [CODE_W-1:0]      mem_rdata,
    output logic                   err_sbe_evt,
    output logic                   err_mbe_evt,
    output logic [AW-1:0]          err_addr
);
    typedef struct packed {
        seq_state_e         st;
        integ_mode_e        mode;
        logic [AW-1:0]      addr;
        logic [DATA_W-1:0]  wdata;
        logic [LANES-1:0]   be;
        logic               rsp_v;
        logic [DATA_W-1:0]  rsp_d;
        logic               rsp_sbe;
        logic               rsp_mbe;
        logic               ev_sbe;
        logic               ev_mbe;
        logic [AW-1:0]      ev_addr;
    } seq_regs_t;

    seq_regs_t         r_q, r_d;
    logic [DATA_W-1:0] enc_in;
    logic [DATA_W-1:0] dec_raw, dec_fix, base_data, merged;
    logic              dec_sbe, dec_mbe, checking;

    ecc_enc i_enc (.data(enc_in), .word(mem_wdata));

    ecc_dec i_dec (
        .word     (mem_rdata),
        .data_raw (dec_raw),
        .data_fix (dec_fix),
        .sbe      (dec_sbe),
        .mbe      (dec_mbe)
    );

    // byte merge of the pending write over the stored word
    always_comb begin
        base_data = r_q.mode[1] ? dec_fix : dec_raw;
        for (int l = 0; l < LANES; l++) begin
            merged[l*8 +: 8] = r_q.be[l] ? r_q.wdata[l*8 +: 8] : base_data[l*8 +: 8];
        end
    end

    always_comb begin
        r_d         = r_q;
        r_d.rsp_v   = 1'b0;
        r_d.ev_sbe  = 1'b0;
        r_d.ev_mbe  = 1'b0;
        mem_en      = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = r_q.addr;
        mem_wmask   = '1;
        enc_in      = r_q.wdata;
        host_ready  = (r_q.st == ST_IDLE);
        checking    = (r_q.mode != MODE_OFF);
        unique case (r_q.st)
            ST_IDLE: begin
                if (host_valid) begin
                    r_d.mode  = integ_mode_e'(mode);
                    r_d.addr  = host_addr;
                    r_d.wdata = host_wdata;
                    r_d.be    = host_be;
                    mem_en    = 1'b1;
                    mem_addr  = host_addr;
                    if (!host_write) begin
                        r_d.st = ST_READ;
                    end else if ((&host_be) || (mode == MODE_OFF)) begin
                        mem_we    = 1'b1;
                        enc_in    = host_wdata;
                        mem_wmask = {&host_be, host_be};
                    end else begin
                        r_d.st = ST_MERGE;
                    end
                end
            end
            ST_READ: begin
                r_d.st      = ST_IDLE;
                r_d.rsp_v   = 1'b1;
                r_d.rsp_d   = (r_q.mode[1] && dec_sbe) ? dec_fix : dec_raw;
                r_d.rsp_sbe = checking && dec_sbe;
                r_d.rsp_mbe = checking && dec_mbe;
                r_d.ev_sbe  = checking && dec_sbe;
                r_d.ev_mbe  = checking && dec_mbe;
                r_d.ev_addr = r_q.addr;
                if ((r_q.mode == MODE_SCRUB) && dec_sbe) begin
                    mem_en = 1'b1;
                    mem_we = 1'b1;
                    enc_in = dec_fix;
                end
            end
            ST_MERGE: begin
                r_d.st      = ST_IDLE;
                r_d.ev_sbe  = dec_sbe;
                r_d.ev_mbe  = dec_mbe;
                r_d.ev_addr = r_q.addr;
                if (!dec_mbe) begin
                    mem_en = 1'b1;
                    mem_we = 1'b1;
                    enc_in = merged;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid   = r_q.rsp_v;
    assign rsp_data    = r_q.rsp_d;
    assign rsp_sbe     = r_q.rsp_sbe;
    assign rsp_mbe     = r_q.rsp_mbe;
    assign err_sbe_evt = r_q.ev_sbe;
    assign err_mbe_evt = r_q.ev_mbe;
    assign err_addr    = r_q.ev_addr;
endmodule

// File: rtl/ecc_seq_chk.sv
module ecc_seq_chk
    import ecc_seq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode,
    input logic               host_valid,
    input logic               host_ready,
    input logic               host_write,
    input logic [LANES-1:0]   host_be,
    input logic               rsp_valid,
    input logic               mem_en,
    input logic               mem_we,
    input logic [MASK_W-1:0]  mem_wmask,
    input logic               err_sbe_evt,
    input logic               err_mbe_evt
);
    assert_full_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && host_write && (&host_be))
        |-> (mem_en && mem_we && (&mem_wmask)));

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && !host_write) |=> ##1 rsp_valid);

    assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && (mode == 2'b00)) |=> ##1 (!err_sbe_evt && !err_mbe_evt));

    assert_mbe_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_mbe_evt |-> $past(!(mem_en && mem_we)));

    assert_rmw_full_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && !host_ready) |-> (&mem_wmask));

    assert_off_partial_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && host_write && (mode == 2'b00))
        |-> (mem_we && (mem_wmask[LANES-1:0] == host_be) && (mem_wmask[LANES] == (&host_be))));

    assert_evt_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_sbe_evt && err_mbe_evt));

    assert_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && !host_write) |=> !host_ready);
endmodule

bind ecc_seq ecc_seq_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .host_valid  (host_valid),
    .host_ready  (host_ready),
    .host_write  (host_write),
    .host_be     (host_be),
    .rsp_valid   (rsp_valid),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_wmask   (mem_wmask),
    .err_sbe_evt (err_sbe_evt),
    .err_mbe_evt (err_mbe_evt)
);

// File: tb/test_ecc_seq.sv
`timescale 1ns/1ps
module test_ecc_seq;
    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b10;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic        host_write = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic [7:0]  host_be = '0;
    logic        rsp_valid, rsp_sbe, rsp_mbe;
    logic [63:0] rsp_data;
    logic        mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [8:0]  mem_wmask;
    logic [71:0] mem_wdata;
    logic [71:0] mem_rdata = '0;
    logic        err_sbe_evt, err_mbe_evt;
    logic [AW-1:0] err_addr;

    logic [71:0] mem_model [WORDS];
    logic [63:0] ref_data  [WORDS];
    int          rd_cnt = 0, wr_cnt = 0;
    logic        inj_en = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [71:0] inj_mask = '0;

    int n_chk = 0, n_fail = 0;

    // observations of the last operation
    logic        o_rsp_v, o_sbe, o_mbe, o_ev_s, o_ev_m, o_stall;
    logic [63:0] o_data;
    logic [AW-1:0] o_ev_a;
    int          o_rd, o_wr;

    always #2 clk = ~clk;

    ecc_seq #(.AW(AW)) i_ecc_seq (.*);

    always @(posedge clk) begin
        if (inj_en) begin
            mem_model[inj_addr] <= mem_model[inj_addr] ^ inj_mask;
        end else if (mem_en) begin
            if (mem_we) begin
                for (int l = 0; l < 9; l++)
                    if (mem_wmask[l]) mem_model[mem_addr][l*8 +: 8] <= mem_wdata[l*8 +: 8];
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem_model[mem_addr];
                rd_cnt    <= rd_cnt + 1;
            end
        end
    end

    function automatic logic [63:0] merge(input logic [63:0] old_d, input logic [63:0] new_d,
                                          input logic [7:0] be);
        logic [63:0] m;
        for (int l = 0; l < 8; l++) m[l*8 +: 8] = be[l] ? new_d[l*8 +: 8] : old_d[l*8 +: 8];
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input logic [71:0] act,
                         input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic inject(input logic [AW-1:0] a, input logic [71:0] m);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = a; inj_mask = m;
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic run_op(input logic wr, input logic [AW-1:0] a, input logic [63:0] d,
                          input logic [7:0] be, input logic [1:0] md);
        int r0, w0;
        @(negedge clk);
        mode = md; host_valid = 1'b1; host_write = wr; host_addr = a;
        host_wdata = d; host_be = be;
        r0 = rd_cnt; w0 = wr_cnt;
        @(posedge clk);
        @(negedge clk);
        host_valid = 1'b0;
        o_stall = !host_ready;
        @(posedge clk);
        @(negedge clk);
        o_rsp_v = rsp_valid; o_data = rsp_data; o_sbe = rsp_sbe; o_mbe = rsp_mbe;
        o_ev_s = err_sbe_evt; o_ev_m = err_mbe_evt; o_ev_a = err_addr;
        @(negedge clk);
        o_rd = rd_cnt - r0; o_wr = wr_cnt - w0;
    endtask

    task automatic full_write(input logic [AW-1:0] a, input logic [63:0] d);
        run_op(1'b1, a, d, 8'hFF, 2'b10);
        ref_data[a] = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [71:0] saved;
        logic [63:0] d;
        logic [7:0]  be;
        logic [1:0]  md;
        logic [AW-1:0] a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < WORDS; i++) mem_model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state
        check(host_ready && !rsp_valid && !err_sbe_evt && !err_mbe_evt && !mem_en,
              "R12 reset idle", {host_ready, rsp_valid, err_sbe_evt, err_mbe_evt, mem_en},
              72'b10000);
        rst_n = 1'b1;

        for (int i = 0; i < WORDS; i++) full_write(AW'(i), {$urandom, $urandom});

        // R1: full write, one access, no stall, data in low bits, clean readback
        run_op(1'b1, 6'd1, 64'hA5A5_0F0F_1234_5678, 8'hFF, 2'b11);
        ref_data[1] = 64'hA5A5_0F0F_1234_5678;
        check(o_rd == 0 && o_wr == 1 && !o_stall, "R1 single write", {o_rd[7:0], o_wr[7:0]}, 16'h0001);
        check(mem_model[1][63:0] == ref_data[1], "R1 stored data", mem_model[1][63:0], ref_data[1]);
        run_op(1'b0, 6'd1, '0, '0, 2'b10);
        check(o_rsp_v && o_data == ref_data[1] && !o_sbe && !o_mbe, "R1 R2 readback",
              o_data, ref_data[1]);
        check(o_stall, "R12 read stall", o_stall, 1);

        // R9: partial write in mode 00
        saved = mem_model[3];
        run_op(1'b1, 6'd3, 64'h1111_2222_3333_4444, 8'h0F, 2'b00);
        check(o_rd == 0 && o_wr == 1, "R9 no read", o_rd, 0);
        check(mem_model[3] == {saved[71:32], 32'h3333_4444}, "R9 lanes", mem_model[3],
              {saved[71:32], 32'h3333_4444});
        full_write(6'd3, ref_data[3]);

        // R3: mode 00 returns corrupted bits unchecked
        inject(6'd4, (72'd1 << 5) | (72'd1 << 40));
        run_op(1'b0, 6'd4, '0, '0, 2'b00);
        check(o_data == (ref_data[4] ^ ((64'd1 << 5) | (64'd1 << 40))), "R3 raw data", o_data,
              ref_data[4] ^ ((64'd1 << 5) | (64'd1 << 40)));
        check(!o_sbe && !o_mbe && !o_ev_s && !o_ev_m, "R3 no flags", {o_sbe, o_mbe, o_ev_s, o_ev_m}, 0);
        full_write(6'd4, ref_data[4]);

        // R4: detect only
        inject(6'd5, 72'd1 << 17);
        run_op(1'b0, 6'd5, '0, '0, 2'b01);
        check(o_data == (ref_data[5] ^ (64'd1 << 17)), "R4 uncorrected", o_data,
              ref_data[5] ^ (64'd1 << 17));
        check(o_sbe && !o_mbe && o_ev_s && !o_ev_m && o_ev_a == 6'd5 && o_wr == 0, "R4 flag",
              {o_sbe, o_ev_s, o_ev_a}, {2'b11, 6'd5});

        // R5: correct, check bit and data bit flips
        run_op(1'b0, 6'd5, '0, '0, 2'b10);
        check(o_data == ref_data[5] && o_sbe && o_ev_s && !o_ev_m, "R5 data bit", o_data, ref_data[5]);
        check(o_wr == 0 && mem_model[5][17] != ref_data[5][17], "R5 no writeback", o_wr, 0);
        full_write(6'd6, 64'h0123_4567_89AB_CDEF);
        saved = mem_model[6];
        inject(6'd6, 72'd1 << 66);
        run_op(1'b0, 6'd6, '0, '0, 2'b10);
        check(o_data == ref_data[6] && o_sbe && !o_mbe, "R5 check bit", o_data, ref_data[6]);

        // R7: scrub restores the stored word
        run_op(1'b0, 6'd6, '0, '0, 2'b11);
        check(o_data == ref_data[6] && o_sbe && o_wr == 1, "R7 scrub write", o_wr, 1);
        check(mem_model[6] == saved, "R7 restored", mem_model[6], saved);

        // R6: double errors, never corrected, no write-back
        inject(6'd7, (72'd1 << 2) | (72'd1 << 70));
        for (int m = 1; m < 4; m++) begin
            run_op(1'b0, 6'd7, '0, '0, 2'(m));
            check(o_mbe && !o_sbe && o_ev_m && !o_ev_s && o_ev_a == 6'd7, "R6 R11 mbe flag",
                  {o_mbe, o_sbe, o_ev_m, o_ev_s}, 4'b1010);
            check(o_data == (ref_data[7] ^ 64'd4) && o_wr == 0, "R6 raw no write", o_data,
                  ref_data[7] ^ 64'd4);
        end

        // R10: partial write on a double error is cancelled
        saved = mem_model[7];
        run_op(1'b1, 6'd7, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01, 2'b10);
        check(o_ev_m && o_ev_a == 6'd7 && o_rd == 1 && o_wr == 0, "R10 abort",
              {o_ev_m, o_rd[3:0], o_wr[3:0]}, {1'b1, 4'd1, 4'd0});
        check(mem_model[7] == saved, "R10 memory kept", mem_model[7], saved);
        full_write(6'd7, ref_data[7]);

        // R8: partial write over a single error in an untouched byte
        inject(6'd8, 72'd1 << 60);
        run_op(1'b1, 6'd8, 64'hDEAD_BEEF_CAFE_F00D, 8'h33, 2'b11);
        check(o_rd == 1 && o_wr == 1 && o_stall && o_ev_s, "R8 sequence",
              {o_rd[3:0], o_wr[3:0], o_stall}, {4'd1, 4'd1, 1'b1});
        ref_data[8] = merge(ref_data[8], 64'hDEAD_BEEF_CAFE_F00D, 8'h33);
        run_op(1'b0, 6'd8, '0, '0, 2'b10);
        check(o_data == ref_data[8] && !o_sbe && !o_mbe, "R8 merged clean", o_data, ref_data[8]);
        inject(6'd9, 72'd1 << 63);
        run_op(1'b1, 6'd9, 64'h0, 8'h01, 2'b01);
        ref_data[9] = merge(ref_data[9] ^ (64'd1 << 63), 64'h0, 8'h01);
        run_op(1'b0, 6'd9, '0, '0, 2'b10);
        check(o_data == ref_data[9] && !o_sbe, "R8 detect merge raw", o_data, ref_data[9]);

        // random mix
        for (int i = 0; i < 400; i++) begin
            a  = AW'($urandom_range(0, WORDS - 1));
            md = 2'($urandom_range(1, 3));
            d  = {$urandom, $urandom};
            if (i % 10 == 0) begin
                saved = mem_model[a];
                inject(a, 72'd1 << $urandom_range(0, 71));
                run_op(1'b0, a, '0, '0, 2'b11);
                check(o_data == ref_data[a] && o_sbe && o_ev_s && o_ev_a == a, "R5 R7 random fix",
                      o_data, ref_data[a]);
                check(mem_model[a] == saved, "R7 random scrub", mem_model[a], saved);
            end else if ($urandom_range(0, 1) == 1) begin
                be = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
                run_op(1'b1, a, d, be, md);
                ref_data[a] = merge(ref_data[a], d, be);
                check(o_stall == (be != 8'hFF), "R12 random stall", o_stall, be != 8'hFF);
            end else begin
                run_op(1'b0, a, '0, '0, md);
                check(o_rsp_v && o_data == ref_data[a] && !o_sbe && !o_mbe, "R2 random read",
                      o_data, ref_data[a]);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule